// File: doc/BRIEF.md
# Cycle-to-Nanosecond Time Scaler

This block turns a reading of a free-running cycle counter into a 64-bit system time in nanoseconds. Each request carries the live counter value and a calibration record. The record holds a base time in nanoseconds, the counter value at which that base time was taken, a signed normalising shift, an unsigned 32-bit fractional multiplier, and the record's version number, read once before and once after the other fields.

The block finds the elapsed ticks since the record was taken and scales them with the signed shift. It then multiplies them by the fraction, keeping all 96 product bits, drops the 32 fractional bits and adds the base time. The record may be stale, so the tick count can exceed 2^32. The product still cannot wrap in that case.

If the two version reads disagree, or the version is odd (the record was being rewritten), the result is marked for retry. The caller then reads the record again and reissues the request. Requests are accepted on a valid/ready handshake, and each accepted request produces exactly one result three cycles later.

Top module: `cyc2ns_scaler`

## Requirements
- R1: `req_ready` is low while `rst` is high. It is high on every cycle after the first clock edge with `rst` low.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `res_valid` high for exactly one cycle, after the third following edge. `res_valid` is never high at any other time.
- R3: The elapsed tick count is `cnt_now - snap_stamp`, taken modulo 2^64, so a counter value below the stamp wraps.
- R4: `snap_shift` is two's complement, limited to -31..+31. A value of zero or more shifts the tick count left by that amount, and bits leaving bit 63 are lost. A negative value shifts it right by its magnitude.
- R5: `snap_mul` is an unsigned fraction with its binary point above bit 31. The scaled count is multiplied with all 96 product bits kept, so tick counts of 2^32 or more give exact results.
- R6: The 32 fractional product bits are truncated, not rounded. A product of 1.5 ns, for example, contributes 1 ns.
- R7: `res_ns` = `snap_base_ns` + the integer part of the product, modulo 2^64.
- R8: If `snap_ver_pre` is odd, the result has `res_retry` = 1 and `res_ns` = 0.
- R9: If `snap_ver_pre` differs from `snap_ver_post`, the result has `res_retry` = 1 and `res_ns` = 0. An even, matching version gives `res_retry` = 0.
- R10: Reset empties the pipeline. A request accepted before `rst` rises yields no result after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| cnt_now | input | 64 | Live cycle counter value |
| snap_base_ns | input | 64 | Record base time in ns |
| snap_stamp | input | 64 | Counter value at which the record was taken |
| snap_shift | input | 6 | Signed normalising shift |
| snap_mul | input | 32 | Unsigned 0.32 fractional multiplier |
| snap_ver_pre | input | 32 | Version read before the record fields |
| snap_ver_post | input | 32 | Version read after the record fields |
| res_valid | output | 1 | Result present (one cycle) |
| res_retry | output | 1 | Record torn or in update; reissue |
| res_ns | output | 64 | System time in ns (0 on retry) |

## Verification
The bench drives tick counts of several times 2^32. A design that kept only a 64-bit product would return a time seconds behind the correct one. The bench also uses a counter value below the stamp, where an unsigned compare or a missing wrap would show. Shifts of +31 and -31 are included, where reversing the shift direction or sign-extending the tick count gives wildly wrong values.

A product with a half-nanosecond fraction shows rounding in place of truncation. A base time near 2^64 checks the final wrap. Odd and mismatched versions must yield a retry with zero time. A reset in the middle of a request must not leak a stale result.

// File: rtl/cyc2ns_pkg.sv
package cyc2ns_pkg;
  localparam int unsigned NS_W_DEF    = 64;
  localparam int unsigned FRAC_W_DEF  = 32;
  localparam int unsigned SHIFT_W_DEF = 6;
  localparam int unsigned VER_W_DEF   = 32;
  localparam int unsigned LATENCY     = 3;
endpackage

// File: rtl/c2n_front.sv
module c2n_front #(
  parameter int unsigned NS_W    = cyc2ns_pkg::NS_W_DEF,
  parameter int unsigned FRAC_W  = cyc2ns_pkg::FRAC_W_DEF,
  parameter int unsigned SHIFT_W = cyc2ns_pkg::SHIFT_W_DEF,
  parameter int unsigned VER_W   = cyc2ns_pkg::VER_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take,
  input  logic [NS_W-1:0]           cnt_now,
  input  logic [NS_W-1:0]           base_ns,
  input  logic [NS_W-1:0]           stamp,
  input  logic signed [SHIFT_W-1:0] shift,
  input  logic [FRAC_W-1:0]         mul,
  input  logic [VER_W-1:0]          ver_pre,
  input  logic [VER_W-1:0]          ver_post,
  output logic                      s1_valid,
  output logic                      s1_retry,
  output logic [NS_W-1:0]           s1_ticks,
  output logic [FRAC_W-1:0]         s1_mul,
  output logic [NS_W-1:0]           s1_base
);
  logic [NS_W-1:0]    raw_ticks;
  logic [NS_W-1:0]    norm_ticks;
  logic [SHIFT_W-1:0] shift_mag;
  logic               torn;

  assign raw_ticks = cnt_now - stamp;
  assign shift_mag = -shift;
  assign torn      = ver_pre[0] | (ver_pre != ver_post);

  always_comb begin
    if (shift[SHIFT_W-1]) norm_ticks = raw_ticks >> shift_mag;
    else                  norm_ticks = raw_ticks << shift;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_retry <= 1'b0;
      s1_ticks <= '0;
      s1_mul   <= '0;
      s1_base  <= '0;
    end else begin
      s1_valid <= take;
      s1_retry <= take & torn;
      s1_ticks <= (take && !torn) ? norm_ticks : '0;
      s1_mul   <= (take && !torn) ? mul        : '0;
      s1_base  <= (take && !torn) ? base_ns    : '0;
    end
  end
endmodule

// File: rtl/c2n_mul.sv
module c2n_mul #(
  parameter int unsigned NS_W   = cyc2ns_pkg::NS_W_DEF,
  parameter int unsigned FRAC_W = cyc2ns_pkg::FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_retry,
  input  logic [NS_W-1:0]   s1_ticks,
  input  logic [FRAC_W-1:0] s1_mul,
  input  logic [NS_W-1:0]   s1_base,
  output logic              s2_valid,
  output logic              s2_retry,
  output logic [NS_W-1:0]   s2_hi_prod,
  output logic [FRAC_W-1:0] s2_lo_int,
  output logic [NS_W-1:0]   s2_base
);
  localparam int unsigned HI_W = NS_W - FRAC_W;
  localparam int unsigned LO_P = 2 * FRAC_W;

  logic [HI_W-1:0]   ticks_hi;
  logic [FRAC_W-1:0] ticks_lo;
  logic [NS_W-1:0]   hi_prod;
  logic [LO_P-1:0]   lo_prod;

  assign ticks_hi = s1_ticks[NS_W-1:FRAC_W];
  assign ticks_lo = s1_ticks[FRAC_W-1:0];
  assign hi_prod  = NS_W'(ticks_hi) * NS_W'(s1_mul);
  assign lo_prod  = LO_P'(ticks_lo) * LO_P'(s1_mul);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid   <= 1'b0;
      s2_retry   <= 1'b0;
      s2_hi_prod <= '0;
      s2_lo_int  <= '0;
      s2_base    <= '0;
    end else begin
      s2_valid   <= s1_valid;
      s2_retry   <= s1_retry;
      s2_hi_prod <= hi_prod;
      s2_lo_int  <= lo_prod[LO_P-1:FRAC_W];
      s2_base    <= s1_base;
    end
  end
endmodule

// File: rtl/cyc2ns_scaler.sv
module cyc2ns_scaler #(
  parameter int unsigned NS_W    = cyc2ns_pkg::NS_W_DEF,
  parameter int unsigned FRAC_W  = cyc2ns_pkg::FRAC_W_DEF,
  parameter int unsigned SHIFT_W = cyc2ns_pkg::SHIFT_W_DEF,
  parameter int unsigned VER_W   = cyc2ns_pkg::VER_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [NS_W-1:0]           cnt_now,
  input  logic [NS_W-1:0]           snap_base_ns,
  input  logic [NS_W-1:0]           snap_stamp,
  input  logic signed [SHIFT_W-1:0] snap_shift,
  input  logic [FRAC_W-1:0]         snap_mul,
  input  logic [VER_W-1:0]          snap_ver_pre,
  input  logic [VER_W-1:0]          snap_ver_post,
  output logic                      res_valid,
  output logic                      res_retry,
  output logic [NS_W-1:0]           res_ns
);
  logic              take;
  logic              s1_valid, s1_retry, s2_valid, s2_retry;
  logic [NS_W-1:0]   s1_ticks, s1_base, s2_hi_prod, s2_base;
  logic [FRAC_W-1:0] s1_mul, s2_lo_int;

  assign take = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  c2n_front #(.NS_W(NS_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .VER_W(VER_W)) u_front (
    .clk(clk), .rst(rst), .take(take),
    .cnt_now(cnt_now), .base_ns(snap_base_ns), .stamp(snap_stamp),
    .shift(snap_shift), .mul(snap_mul),
    .ver_pre(snap_ver_pre), .ver_post(snap_ver_post),
    .s1_valid(s1_valid), .s1_retry(s1_retry), .s1_ticks(s1_ticks),
    .s1_mul(s1_mul), .s1_base(s1_base)
  );

  c2n_mul #(.NS_W(NS_W), .FRAC_W(FRAC_W)) u_mul (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_retry(s1_retry), .s1_ticks(s1_ticks),
    .s1_mul(s1_mul), .s1_base(s1_base),
    .s2_valid(s2_valid), .s2_retry(s2_retry), .s2_hi_prod(s2_hi_prod),
    .s2_lo_int(s2_lo_int), .s2_base(s2_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_retry <= 1'b0;
      res_ns    <= '0;
    end else begin
      res_valid <= s2_valid;
      res_retry <= s2_retry;
      res_ns    <= s2_base + s2_hi_prod + NS_W'(s2_lo_int);
    end
  end
endmodule

// File: rtl/cyc2ns_scaler_chk.sv
module cyc2ns_scaler_chk #(
  parameter int unsigned NS_W  = cyc2ns_pkg::NS_W_DEF,
  parameter int unsigned VER_W = cyc2ns_pkg::VER_W_DEF
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VER_W-1:0] snap_ver_pre,
  input logic [VER_W-1:0] snap_ver_post,
  input logic             res_valid,
  input logic             res_retry,
  input logic [NS_W-1:0]  res_ns
);
  logic acc;
  assign acc = req_valid & req_ready;

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> req_ready);

  p_result_latency_r2: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##3 res_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> $past(acc, 3));

  p_retry_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_retry) |-> (res_ns == '0));

  p_torn_retry_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && (snap_ver_pre != snap_ver_post || snap_ver_pre[0])) |-> ##3 res_retry);

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> !res_valid);
endmodule

bind cyc2ns_scaler cyc2ns_scaler_chk #(.NS_W(NS_W), .VER_W(VER_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .snap_ver_pre(snap_ver_pre), .snap_ver_post(snap_ver_post),
  .res_valid(res_valid), .res_retry(res_retry), .res_ns(res_ns)
);

// File: tb/sim_cyc2ns_scaler.sv
`timescale 1ns/1ps
module sim_cyc2ns_scaler;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [63:0]       cnt_now = '0, snap_base_ns = '0, snap_stamp = '0;
  logic signed [5:0] snap_shift = '0;
  logic [31:0]       snap_mul = '0, snap_ver_pre = '0, snap_ver_post = '0;
  logic              res_valid, res_retry;
  logic [63:0]       res_ns;

  always #2 clk = ~clk;

  cyc2ns_scaler u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cnt_now(cnt_now), .snap_base_ns(snap_base_ns), .snap_stamp(snap_stamp),
    .snap_shift(snap_shift), .snap_mul(snap_mul),
    .snap_ver_pre(snap_ver_pre), .snap_ver_post(snap_ver_post),
    .res_valid(res_valid), .res_retry(res_retry), .res_ns(res_ns)
  );

  typedef struct {
    int          due;
    bit          retry;
    logic [63:0] ns;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;

  function automatic logic [63:0] model(logic [63:0] base, logic [63:0] now,
                                        logic [63:0] stamp, int sh, logic [31:0] mul);
    logic [63:0]  d;
    logic [95:0]  prod;
    d = now - stamp;
    if (sh >= 0) d = d << sh;
    else         d = d >> (-sh);
    prod = {32'd0, d} * {64'd0, mul};
    return base + prod[95:32];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (q.size() != 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check(res_valid === 1'b1, {e.tag, " R2 valid"}, 64'(res_valid), 64'd1);
      check(res_retry === e.retry, {e.tag, " R9 retry"}, 64'(res_retry), 64'(e.retry));
      check(res_ns === e.ns, e.tag, res_ns, e.ns);
    end else begin
      check(res_valid === 1'b0, "R2 idle", 64'(res_valid), 64'd0);
    end
  endtask

  task automatic send(logic [63:0] base, logic [63:0] now, logic [63:0] stamp,
                      int sh, logic [31:0] mul, logic [31:0] vpre,
                      logic [31:0] vpost, string tag);
    exp_t e;
    snap_base_ns  = base;
    cnt_now       = now;
    snap_stamp    = stamp;
    snap_shift    = 6'(sh);
    snap_mul      = mul;
    snap_ver_pre  = vpre;
    snap_ver_post = vpost;
    req_valid     = 1'b1;
    e.due   = cyc + 3;
    e.retry = vpre[0] || (vpre != vpost);
    e.ns    = e.retry ? 64'd0 : model(base, now, stamp, sh, mul);
    e.tag   = tag;
    q.push_back(e);
    tick();
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (3) tick();
    check(req_ready === 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
    check(res_valid === 1'b0, "R10 valid in reset", 64'(res_valid), 64'd0);
    rst = 1'b0;
    tick();
    check(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

    send(64'd1000, 64'd5000, 64'd3000, 0, 32'h8000_0000, 32'd2, 32'd2, "R5 basic");
    check(1'b1, "R5", 0, 0);
    send(64'd0, 64'd200, 64'd100, 3, 32'h4000_0000, 32'd4, 32'd4, "R4 left shift");
    send(64'd7, 64'd1000, 64'd0, -2, 32'hFFFF_FFFF, 32'd4, 32'd4, "R4 right shift");
    send(64'd0, 64'h5_0000_0000, 64'd0, 0, 32'h8000_0000, 32'd6, 32'd6, "R5 large delta");
    send(64'd123, 64'h7_1234_5678, 64'h1000, 0, 32'hFFFF_FFFF, 32'd6, 32'd6, "R5 large delta full mul");
    send(64'd0, 64'd10, 64'd20, 0, 32'h0000_1000, 32'd8, 32'd8, "R3 counter wrap");
    send(64'd0, 64'd3, 64'd0, 0, 32'h8000_0000, 32'd8, 32'd8, "R6 truncate 1.5");
    send(64'hFFFF_FFFF_FFFF_FFFB, 64'd40, 64'd0, 0, 32'h8000_0000, 32'd8, 32'd8, "R7 add wrap");
    send(64'd0, 64'h3_0000_0001, 64'd0, 31, 32'h0000_0003, 32'd8, 32'd8, "R4 shift +31 lost bits");
    send(64'd5, 64'hFFFF_0000_0000_0000, 64'd0, -31, 32'hC000_0000, 32'd8, 32'd8, "R4 shift -31");
    send(64'd99, 64'd500, 64'd0, 0, 32'h8000_0000, 32'd9, 32'd9, "R8 odd version");
    send(64'd99, 64'd500, 64'd0, 0, 32'h8000_0000, 32'd10, 32'd12, "R9 version mismatch");
    send(64'd99, 64'd500, 64'd0, 0, 32'h8000_0000, 32'd12, 32'd12, "R9 version match");
    idle(5);

    send(64'd1, 64'd1000, 64'd0, 0, 32'h8000_0000, 32'd2, 32'd2, "R10 lost");
    rst = 1'b1;
    void'(q.pop_back());
    req_valid = 1'b0;
    tick();
    tick();
    rst = 1'b0;
    idle(6);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] b, n, s;
      logic [31:0] v;
      b = {$urandom, $urandom};
      n = {$urandom, $urandom};
      s = {$urandom, $urandom};
      v = $urandom_range(7);
      send(b, n, s, int'($urandom_range(62)) - 31, $urandom,
           v, (i % 5 == 0) ? v + 32'd2 : v, "R5 random");
      if (i % 17 == 0) idle(2);
    end
    idle(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule